// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two bidirectional data buses, called A and B, that are split into independent lanes. With the defaults there are two lanes of eight bits each. Every lane has its own control set. Each lane holds two capture registers. One stores the A bus value for later transfer toward B, and the other stores the B bus value for later transfer toward A. A select per direction chooses what the driven bus carries: the live value on the opposite bus, or the value captured earlier.

The pads are modelled as separate input, output and output-enable vectors for each bus. A pad wrapper outside the block combines them. An active-low enable per lane either isolates both buses or lets the lane drive one of them. A direction bit picks which bus is driven. Capture does not depend on the enable or the direction. Each capture strobe is sampled on the rising edge of the common clock, so a lane can fill a register while it is isolated and release the value later.

Top module: `dual_path_xcvr`

## Requirements
- R1: The A-side register of lane k loads `a_in[8k+7:8k]` at a rising clock edge where `cap_ab[k]` is 1, whatever `oe_n` and `dir_b` are. Otherwise it holds its value.
- R2: The B-side register of lane k loads `b_in[8k+7:8k]` at a rising clock edge where `cap_ba[k]` is 1, whatever `oe_n` and `dir_b` are. Otherwise it holds its value.
- R3: While `oe_n[k]` is 1 (isolation), every bit of lane k in `a_oe`, `b_oe`, `a_out` and `b_out` is 0.
- R4: While `oe_n[k]` is 0, a `dir_b[k]` of 1 sets all of lane k's `b_oe` bits and clears its `a_oe` bits. A `dir_b[k]` of 0 does the reverse.
- R5: When lane k drives B and `sel_ab[k]` is 0, its `b_out` bits equal the current `a_in` bits of that lane in the same cycle, with no clock in the path.
- R6: When lane k drives B and `sel_ab[k]` is 1, its `b_out` bits equal the A-side register of that lane.
- R7: When lane k drives A, its `a_out` bits equal the current `b_in` bits if `sel_ba[k]` is 0, and the B-side register if it is 1.
- R8: A capture in a cycle where the register is driving a bus in stored mode shows the old value until the edge and the new value from that edge on.
- R9: Lane k's outputs depend only on lane k's controls and lane k's bus bits. Lane k covers bits `[8k+7:8k]`.
- R10: A rising edge with `rst_n` at 0 clears both registers of every lane to 0, and this takes priority over capture.
- R11: Every `a_out` or `b_out` bit whose enable bit is 0 is driven to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; capture strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of all registers |
| oe_n | input | LANES | Per-lane output enable, active low |
| dir_b | input | LANES | Per-lane direction: 1 drives B, 0 drives A |
| cap_ab | input | LANES | Per-lane strobe that loads the A-side register from `a_in` |
| cap_ba | input | LANES | Per-lane strobe that loads the B-side register from `b_in` |
| sel_ab | input | LANES | Per-lane source for B: 0 live A, 1 stored A |
| sel_ba | input | LANES | Per-lane source for A: 0 live B, 1 stored B |
| a_in | input | LANE_W*LANES | Value seen on the A pads |
| a_out | output | LANE_W*LANES | Value to drive onto the A pads |
| a_oe | output | LANE_W*LANES | Per-bit drive enable for the A pads |
| b_in | input | LANE_W*LANES | Value seen on the B pads |
| b_out | output | LANE_W*LANES | Value to drive onto the B pads |
| b_oe | output | LANE_W*LANES | Per-bit drive enable for the B pads |

## Verification
The bench builds the block with its defaults: two lanes of eight bits. Two lanes are enough to show lane independence, because random control words regularly put the lanes in opposite directions, modes and enable states in the same cycle. Eight-bit lanes keep the data random enough that a stale or swapped register value is caught at once. Directed steps load registers during isolation, capture in the same cycle as a stored-mode drive, and reset with capture asserted.

// File: rtl/xcvr_pkg.sv
// Package: shared defaults and the per-lane control bundle of the transceiver.
// Assumes: every lane uses the same control layout.
package xcvr_pkg;

    localparam int LANE_W_DEF = 8;
    localparam int LANES_DEF  = 2;

    // Control set of one lane
    typedef struct packed {
        logic oe_n;    // active-low output enable
        logic dir_b;   // 1: drive B bus, 0: drive A bus
        logic cap_ab;  // load the A-side register
        logic cap_ba;  // load the B-side register
        logic sel_ab;  // B source: 0 live, 1 stored
        logic sel_ba;  // A source: 0 live, 1 stored
    } lane_ctrl_t;

endpackage

// File: rtl/xcvr_capture_reg.sv
// Module: one capture register with load enable.
// Assumes: rst_n is synchronous, active low, and wins over the load enable.
module xcvr_capture_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Clear on reset, otherwise load d when the strobe is high
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end

endmodule

// File: rtl/xcvr_lane.sv
// Module: one lane of the transceiver: two capture registers, two source
// multiplexers and the enable decode for both buses.
// Assumes: capture never depends on enable or direction; undriven outputs are 0.
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int W = LANE_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  lane_ctrl_t   ctrl,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe
);

    logic [W-1:0] a_q;
    logic [W-1:0] b_q;
    logic [W-1:0] to_b;
    logic [W-1:0] to_a;
    logic         drive_a;
    logic         drive_b;

    xcvr_capture_reg #(.W(W)) u_a_store (
        .clk  (clk),
        .rst_n(rst_n),
        .load (ctrl.cap_ab),
        .d    (a_in),
        .q    (a_q)
    );

    xcvr_capture_reg #(.W(W)) u_b_store (
        .clk  (clk),
        .rst_n(rst_n),
        .load (ctrl.cap_ba),
        .d    (b_in),
        .q    (b_q)
    );

    // Decide which bus, if any, this lane drives
    always_comb begin
        drive_b = !ctrl.oe_n &&  ctrl.dir_b;
        drive_a = !ctrl.oe_n && !ctrl.dir_b;
    end

    // Pick live or stored data for each direction
    always_comb begin
        to_b = ctrl.sel_ab ? a_q : a_in;
        to_a = ctrl.sel_ba ? b_q : b_in;
    end

    // Gate values and form per-bit enables
    always_comb begin
        b_out = drive_b ? to_b : '0;
        a_out = drive_a ? to_a : '0;
        b_oe  = {W{drive_b}};
        a_oe  = {W{drive_a}};
    end

endmodule

// File: rtl/dual_path_xcvr.sv
// Module: top of the registered bidirectional transceiver; replicates one
// lane per control set over the A and B buses.
// Assumes: pads are split into in/out/enable vectors by a wrapper outside.
module dual_path_xcvr
    import xcvr_pkg::*;
#(
    parameter int  LANE_W = LANE_W_DEF,
    parameter int  LANES  = LANES_DEF,
    localparam int BUS_W  = LANE_W * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] oe_n,
    input  logic [LANES-1:0] dir_b,
    input  logic [LANES-1:0] cap_ab,
    input  logic [LANES-1:0] cap_ba,
    input  logic [LANES-1:0] sel_ab,
    input  logic [LANES-1:0] sel_ba,
    input  logic [BUS_W-1:0] a_in,
    output logic [BUS_W-1:0] a_out,
    output logic [BUS_W-1:0] a_oe,
    input  logic [BUS_W-1:0] b_in,
    output logic [BUS_W-1:0] b_out,
    output logic [BUS_W-1:0] b_oe
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_ctrl_t ctrl;

        // Bundle this lane's control bits
        always_comb begin
            ctrl.oe_n   = oe_n[g];
            ctrl.dir_b  = dir_b[g];
            ctrl.cap_ab = cap_ab[g];
            ctrl.cap_ba = cap_ba[g];
            ctrl.sel_ab = sel_ab[g];
            ctrl.sel_ba = sel_ba[g];
        end

        xcvr_lane #(.W(LANE_W)) u_lane (
            .clk  (clk),
            .rst_n(rst_n),
            .ctrl (ctrl),
            .a_in (a_in [g*LANE_W +: LANE_W]),
            .b_in (b_in [g*LANE_W +: LANE_W]),
            .a_out(a_out[g*LANE_W +: LANE_W]),
            .a_oe (a_oe [g*LANE_W +: LANE_W]),
            .b_out(b_out[g*LANE_W +: LANE_W]),
            .b_oe (b_oe [g*LANE_W +: LANE_W])
        );
    end

endmodule

// File: rtl/dual_path_xcvr_chk.sv
// Module: property checker for dual_path_xcvr, attached by bind.
// Assumes: inputs change away from the rising clock edge.
module dual_path_xcvr_chk #(
    parameter int  LANE_W = 8,
    parameter int  LANES  = 2,
    localparam int BUS_W  = LANE_W * LANES
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LANES-1:0] oe_n,
    input logic [LANES-1:0] dir_b,
    input logic [LANES-1:0] cap_ab,
    input logic [LANES-1:0] cap_ba,
    input logic [LANES-1:0] sel_ab,
    input logic [LANES-1:0] sel_ba,
    input logic [BUS_W-1:0] a_in,
    input logic [BUS_W-1:0] a_out,
    input logic [BUS_W-1:0] a_oe,
    input logic [BUS_W-1:0] b_in,
    input logic [BUS_W-1:0] b_out,
    input logic [BUS_W-1:0] b_oe
);

    // R11
    undriven_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_out & ~a_oe) == '0) && ((b_out & ~b_oe) == '0));

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        // R3
        isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
            oe_n[g] |-> (a_oe[g*LANE_W +: LANE_W] == '0) && (b_oe[g*LANE_W +: LANE_W] == '0));

        // R4
        direction_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !oe_n[g] |-> ((&b_oe[g*LANE_W +: LANE_W]) == dir_b[g])
                      && ((|a_oe[g*LANE_W +: LANE_W]) == !dir_b[g]));

        // R5
        live_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!oe_n[g] && dir_b[g] && !sel_ab[g])
            |-> b_out[g*LANE_W +: LANE_W] == a_in[g*LANE_W +: LANE_W]);

        // R7
        live_ba_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!oe_n[g] && !dir_b[g] && !sel_ba[g])
            |-> a_out[g*LANE_W +: LANE_W] == b_in[g*LANE_W +: LANE_W]);

        // R1
        capture_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cap_ab[g] |=> (oe_n[g] || !dir_b[g] || !sel_ab[g]
                || b_out[g*LANE_W +: LANE_W] == $past(a_in[g*LANE_W +: LANE_W])));

        // R2
        capture_ba_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cap_ba[g] |=> (oe_n[g] || dir_b[g] || !sel_ba[g]
                || a_out[g*LANE_W +: LANE_W] == $past(b_in[g*LANE_W +: LANE_W])));

        // R6
        stored_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!oe_n[g] && dir_b[g] && sel_ab[g] && !cap_ab[g])
            |=> (!(!oe_n[g] && dir_b[g] && sel_ab[g]) || $stable(b_out[g*LANE_W +: LANE_W])));

        // R10
        reset_clear_chk: assert property (@(posedge clk)
            !rst_n |=> (oe_n[g] || !dir_b[g] || !sel_ab[g] || b_out[g*LANE_W +: LANE_W] == '0));
    end

endmodule

bind dual_path_xcvr dual_path_xcvr_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .oe_n  (oe_n),
    .dir_b (dir_b),
    .cap_ab(cap_ab),
    .cap_ba(cap_ba),
    .sel_ab(sel_ab),
    .sel_ba(sel_ba),
    .a_in  (a_in),
    .a_out (a_out),
    .a_oe  (a_oe),
    .b_in  (b_in),
    .b_out (b_out),
    .b_oe  (b_oe)
);

// File: tb/tb_dual_path_xcvr.sv
// Bench: directed corner cases and seeded random steps against a bench model.
module tb_dual_path_xcvr;

    localparam int W  = 8;
    localparam int L  = 2;
    localparam int BW = W * L;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [L-1:0]  oe_n, dir_b, cap_ab, cap_ba, sel_ab, sel_ba;
    logic [BW-1:0] a_in, b_in;
    logic [BW-1:0] a_out, a_oe, b_out, b_oe;

    logic [W-1:0]  ref_a [L];
    logic [W-1:0]  ref_b [L];
    int            checks = 0;
    int            fails  = 0;
    bit            done   = 1'b0;

    dual_path_xcvr #(.LANE_W(W), .LANES(L)) dut (
        .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir_b(dir_b),
        .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    always #5 clk = ~clk;

    // Expected {a_out, a_oe, b_out, b_oe} of one lane from the requirements
    function automatic logic [4*W-1:0] expect_lane(input int k);
        logic [W-1:0] ea, eae, eb, ebe;
        logic         da, db;
        db  = !oe_n[k] &&  dir_b[k];                            // R3, R4
        da  = !oe_n[k] && !dir_b[k];
        eb  = db ? (sel_ab[k] ? ref_a[k] : a_in[k*W +: W]) : '0; // R5, R6, R11
        ea  = da ? (sel_ba[k] ? ref_b[k] : b_in[k*W +: W]) : '0; // R7, R11
        ebe = {W{db}};
        eae = {W{da}};
        return {ea, eae, eb, ebe};
    endfunction

    task automatic check_all(input string req);
        for (int k = 0; k < L; k++) begin
            logic [4*W-1:0] got, exp;
            got = {a_out[k*W +: W], a_oe[k*W +: W], b_out[k*W +: W], b_oe[k*W +: W]};
            exp = expect_lane(k);
            checks++;
            if (got !== exp) begin
                fails++;
                $display("FAIL %s lane %0d: actual %h expected %h", req, k, got, exp);
            end
        end
    endtask

    // Drive one step at the falling edge, check, pass the rising edge, update model
    task automatic step(input logic [L-1:0] o, d, ca, cb, sa, sb,
                        input logic [BW-1:0] av, bv, input string req);
        oe_n = o; dir_b = d; cap_ab = ca; cap_ba = cb; sel_ab = sa; sel_ba = sb;
        a_in = av; b_in = bv;
        #1;
        check_all(req);
        @(posedge clk);
        for (int k = 0; k < L; k++) begin
            if (!rst_n) begin                       // R10
                ref_a[k] = '0;
                ref_b[k] = '0;
            end else begin
                if (cap_ab[k]) ref_a[k] = a_in[k*W +: W];   // R1
                if (cap_ba[k]) ref_b[k] = b_in[k*W +: W];   // R2
            end
        end
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd1993));
        for (int k = 0; k < L; k++) begin
            ref_a[k] = '0;
            ref_b[k] = '0;
        end
        rst_n = 1'b0;
        oe_n = '1; dir_b = '0; cap_ab = '0; cap_ba = '0; sel_ab = '0; sel_ba = '0;
        a_in = '0; b_in = '0;
        @(negedge clk);
        step('1, '0, '1, '1, '0, '0, 16'hA5A5, 16'h5A5A, "R10 reset/R3");
        rst_n = 1'b1;

        // R10: registers are zero after reset; stored mode in both directions
        step(2'b00, 2'b01, '0, '0, '1, '1, 16'hFFFF, 16'hFFFF, "R10 stored zero");

        // R1, R3: capture A data while isolated
        step('1, '1, '1, '0, '1, '1, 16'h3C96, 16'h0000, "R1 R3 isolated capture");
        // R6: release the stored A data with other live A bits present
        step('0, '1, '0, '0, '1, '0, 16'hFFFF, 16'h1111, "R6 stored A to B");
        // R2: capture B data while isolated, then release toward A
        step('1, '0, '0, '1, '0, '1, 16'h0000, 16'hC3E1, "R2 R3 isolated capture");
        step('0, '0, '0, '0, '0, '1, 16'h2222, 16'h0000, "R7 stored B to A");

        // R8: capture while driving stored value
        step('0, '1, '1, '0, '1, '0, 16'h7E81, 16'h0000, "R8 before edge");
        step('0, '1, '0, '0, '1, '0, 16'h0000, 16'h0000, "R8 after edge");
        step('0, '0, '0, '1, '0, '1, 16'h0000, 16'h4DB2, "R8 B before edge");
        step('0, '0, '0, '0, '0, '1, 16'hFFFF, 16'hFFFF, "R8 B after edge");

        // R5, R7: live transfers
        step('0, '1, '0, '0, '0, '0, 16'hBEEF, 16'h0000, "R5 live A to B");
        step('0, '0, '0, '0, '0, '0, 16'h0000, 16'hCAFE, "R7 live B to A");

        // R9: lanes in opposite directions and modes
        step(2'b00, 2'b01, 2'b10, 2'b01, 2'b01, 2'b10, 16'h1357, 16'h2468, "R9 split lanes");
        step(2'b10, 2'b10, 2'b00, 2'b00, 2'b11, 2'b11, 16'h9ABC, 16'hDEF0, "R9 one lane isolated");

        // R10: reset with capture asserted clears registers
        rst_n = 1'b0;
        step('1, '1, '1, '1, '1, '1, 16'h5555, 16'hAAAA, "R10 reset over capture");
        rst_n = 1'b1;
        step('0, 2'b01, '0, '0, '1, '1, 16'hFFFF, 16'hFFFF, "R10 cleared");

        // Random steps covering every enable/direction/select mix
        for (int i = 0; i < 3000; i++) begin
            step(L'($urandom), L'($urandom), L'($urandom), L'($urandom),
                 L'($urandom), L'($urandom), BW'($urandom), BW'($urandom),
                 "R1 R2 R4 R5 R6 R7 R9 R11 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung run, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule